// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block holds the programming state of a clock synthesizer: a 9-bit feedback divide value, a 3-bit output divide code, a 4-bit spread-spectrum code and a 2-bit test selector. It can be loaded in two ways. The first is a set of parallel pins gated by an active-low strobe. While the strobe is low the pins pass straight through, and its rising edge freezes them. The second is a three-wire serial port made of data, clock and load lines. Serial data fills a 21-bit shift register. While load is high, the register contents pass through to the active values, and the falling edge of load freezes them.

All pin inputs are asynchronous. Each one passes through a two-flop synchronizer into the system clock domain before any edge on it is detected. A test pin shows one of four sources, chosen by the serially loaded test selector. A one-cycle relock pulse tells the PLL to reacquire lock. It fires whenever the active feedback value changes, and when the master reset input is released. The master reset never alters the loaded values.

Top module: `cfg_loader_top`

## Requirements
- R1: After reset the active values are feedback 30, output code 3'b001, spread code 0 and test selector 0. The relock output and the test pin are low.
- R2: While the synchronized strobe is low, the feedback and output-code outputs follow the parallel pins, and the spread code is held at 0.
- R3: A rising edge of the strobe freezes the active values. Later parallel pin changes have no effect while the strobe stays high.
- R4: With the strobe high, each rising serial clock edge shifts the serial data bit into the shift register. While load stays low, shifting leaves the active values unchanged.
- R5: A rising edge of load transfers the shift register to the active values. The frame is 21 bits, sent first to last in this order: spread code bits 3..0, test selector bits 1..0, three ignored bits, output code bits 2..0, and feedback bits 8..0.
- R6: While load is held high, every serial clock edge updates the active values with the shifted contents. After load falls, further shifting does not change them.
- R7: The test pin is selected by the test selector. 0 drives low. 1 drives the shift register's oldest bit (the first frame bit still held). 2 drives the feedback divider clock input. 3 drives the bank-A clock input.
- R8: The test pin is low whenever the strobe is low, whatever the test selector holds.
- R9: The master reset input leaves all active values unchanged. Its release produces exactly one relock pulse.
- R10: The relock output is high for exactly one cycle after each change of the active feedback value. A change of the output code alone produces no pulse.
- R11: While the strobe is low, serial load activity does not override the parallel values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low block reset |
| mpin_i | input | 9 | Parallel feedback divide value |
| npin_i | input | 3 | Parallel output divide code |
| strobe_n_i | input | 1 | Parallel load strobe, active low |
| ser_dat_i | input | 1 | Serial data |
| ser_clk_i | input | 1 | Serial clock |
| ser_ld_i | input | 1 | Serial load |
| master_rst_i | input | 1 | PLL master reset request |
| fbdiv_clk_i | input | 1 | Feedback divider output, test source |
| banka_clk_i | input | 1 | Bank-A output clock, test source |
| m_o | output | 9 | Active feedback divide value |
| n_o | output | 3 | Active output divide code |
| ss_o | output | 4 | Active spread-spectrum code |
| tsel_o | output | 2 | Active test selector |
| test_o | output | 1 | Test pin |
| relock_o | output | 1 | One-cycle relock request |

## Verification
Two functions can fall in the same cycle. When load is held high, a serial clock edge shifts the register and also transfers its contents to the active values. The bench provokes this by raising load before a full frame is sent. It then checks that the active values equal the frame completed on the last clock, and that the next three bits, sent after load falls, change nothing. A feedback change and a master-reset release can also meet in one relock decision. The bench counts relock pulses around each event and expects exactly one for a feedback change or a release, and none for a change of the output code alone.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
    localparam int M_W     = 9;
    localparam int N_W     = 3;
    localparam int SS_W    = 4;
    localparam int T_W     = 2;
    localparam int PAD_W   = 3;
    localparam int FRAME_W = SS_W + T_W + PAD_W + N_W + M_W;

    // Frame layout: the first serial bit ends in the MSB
    typedef struct packed {
        logic [SS_W-1:0]  ss;
        logic [T_W-1:0]   tsel;
        logic [PAD_W-1:0] pad;
        logic [N_W-1:0]   n;
        logic [M_W-1:0]   m;
    } frame_t;

    typedef enum logic [T_W-1:0] {
        TST_LOW   = 2'd0,
        TST_SHIFT = 2'd1,
        TST_FB    = 2'd2,
        TST_BANKA = 2'd3
    } test_sel_e;

    typedef struct packed {
        logic [M_W-1:0]  m;
        logic [N_W-1:0]  n;
        logic [SS_W-1:0] ss;
        logic [T_W-1:0]  tsel;
        frame_t          sr;
        logic            sclk_p;
        logic            mr_p;
        logic            relock;
    } cfg_state_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= RST_VAL;
                else        chain_q[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= RST_VAL;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cfg_test_mux.sv
module cfg_test_mux
    import cfg_loader_pkg::*;
(
    input  logic [T_W-1:0] sel_i,
    input  logic           par_mode_i,
    input  logic           shift_i,
    input  logic           fb_i,
    input  logic           banka_i,
    output logic           test_o
);
    always_comb begin
        test_o = 1'b0;
        if (!par_mode_i) begin
            case (test_sel_e'(sel_i))
                TST_SHIFT: test_o = shift_i;
                TST_FB:    test_o = fb_i;
                TST_BANKA: test_o = banka_i;
                default:   test_o = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/cfg_loader_top.sv
module cfg_loader_top
    import cfg_loader_pkg::*;
#(
    parameter logic [M_W-1:0] M_RST       = 9'd30,
    parameter logic [N_W-1:0] N_RST       = 3'b001,
    parameter int             SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [M_W-1:0]  mpin_i,
    input  logic [N_W-1:0]  npin_i,
    input  logic            strobe_n_i,
    input  logic            ser_dat_i,
    input  logic            ser_clk_i,
    input  logic            ser_ld_i,
    input  logic            master_rst_i,
    input  logic            fbdiv_clk_i,
    input  logic            banka_clk_i,
    output logic [M_W-1:0]  m_o,
    output logic [N_W-1:0]  n_o,
    output logic [SS_W-1:0] ss_o,
    output logic [T_W-1:0]  tsel_o,
    output logic            test_o,
    output logic            relock_o
);
    localparam int CTRL_W = 5;
    localparam int PIN_W  = M_W + N_W + CTRL_W;
    // strobe idles high so reset does not enter parallel mode
    localparam logic [PIN_W-1:0] PIN_RST = PIN_W'(5'b10000);

    logic [PIN_W-1:0] pins_raw, pins_s;
    logic [M_W-1:0]   m_s;
    logic [N_W-1:0]   n_s;
    logic             strb_s, sdat_s, sclk_s, ld_s, mr_s;

    assign pins_raw = {mpin_i, npin_i, strobe_n_i, ser_dat_i, ser_clk_i,
                       ser_ld_i, master_rst_i};

    cfg_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pins_raw),
        .q_o   (pins_s)
    );

    assign {m_s, n_s, strb_s, sdat_s, sclk_s, ld_s, mr_s} = pins_s;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.sclk_p = sclk_s;
        st_d.mr_p   = mr_s;
        if (!strb_s) begin
            st_d.m  = m_s;
            st_d.n  = n_s;
            st_d.ss = '0;
        end else begin
            if (sclk_s && !st_q.sclk_p) begin
                st_d.sr = frame_t'({st_q.sr[FRAME_W-2:0], sdat_s});
            end
            if (ld_s) begin
                st_d.m    = st_d.sr.m;
                st_d.n    = st_d.sr.n;
                st_d.ss   = st_d.sr.ss;
                st_d.tsel = st_d.sr.tsel;
            end
        end
        st_d.relock = (st_d.m != st_q.m) || (st_q.mr_p && !mr_s);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.m      <= M_RST;
            st_q.n      <= N_RST;
        end else begin
            st_q <= st_d;
        end
    end

    cfg_test_mux u_tmux (
        .sel_i      (st_q.tsel),
        .par_mode_i (!strb_s),
        .shift_i    (st_q.sr[FRAME_W-1]),
        .fb_i       (fbdiv_clk_i),
        .banka_i    (banka_clk_i),
        .test_o     (test_o)
    );

    assign m_o      = st_q.m;
    assign n_o      = st_q.n;
    assign ss_o     = st_q.ss;
    assign tsel_o   = st_q.tsel;
    assign relock_o = st_q.relock;
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk
    import cfg_loader_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            strb_s,
    input logic            ld_s,
    input logic [M_W-1:0]  m_o,
    input logic [N_W-1:0]  n_o,
    input logic [SS_W-1:0] ss_o,
    input logic [T_W-1:0]  tsel_o,
    input logic            test_o,
    input logic            relock_o
);
    AST_SPREAD_OFF_PARALLEL: assert property (@(posedge clk) disable iff (!rst_n)
        !strb_s |=> (ss_o == '0)); // R2

    AST_HOLD_WHEN_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_s && !ld_s) |=> $stable({m_o, n_o, ss_o, tsel_o})); // R3

    AST_TSEL_KEPT_PARALLEL: assert property (@(posedge clk) disable iff (!rst_n)
        !strb_s |=> $stable(tsel_o)); // R2

    AST_TEST_LOW_PARALLEL: assert property (@(posedge clk) disable iff (!rst_n)
        !strb_s |-> !test_o); // R8

    AST_RELOCK_ON_M_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (m_o != $past(m_o)) |-> relock_o); // R10
endmodule

bind cfg_loader_top cfg_loader_chk u_chk (.*);

// File: tb/tb_cfg_loader_top.sv
`timescale 1ns/1ps
module tb_cfg_loader_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] mpin = 9'd0;
    logic [2:0] npin = 3'd0;
    logic       strobe_n = 1'b1;
    logic       sdat = 1'b0, sclk = 1'b0, sld = 1'b0, mr = 1'b0;
    logic       fbclk = 1'b0, baclk = 1'b0;
    logic [8:0] m_o;
    logic [2:0] n_o;
    logic [3:0] ss_o;
    logic [1:0] tsel_o;
    logic       test_o, relock_o;

    int checks = 0;
    int fails = 0;
    int relocks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cfg_loader_top dut (
        .clk (clk), .rst_n (rst_n), .mpin_i (mpin), .npin_i (npin),
        .strobe_n_i (strobe_n), .ser_dat_i (sdat), .ser_clk_i (sclk),
        .ser_ld_i (sld), .master_rst_i (mr), .fbdiv_clk_i (fbclk),
        .banka_clk_i (baclk), .m_o (m_o), .n_o (n_o), .ss_o (ss_o),
        .tsel_o (tsel_o), .test_o (test_o), .relock_o (relock_o)
    );

    always @(posedge clk) if (rst_n && relock_o) relocks++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sdat = b; cyc(4);
        sclk = 1'b1; cyc(4);
        sclk = 1'b0; cyc(4);
    endtask

    function automatic logic [20:0] mk_frame(input logic [3:0] ss, input logic [1:0] t,
                                             input logic [2:0] n, input logic [8:0] m);
        return {ss, t, 3'b101, n, m};
    endfunction

    task automatic send_frame(input logic [20:0] f);
        for (int i = 20; i >= 0; i--) send_bit(f[i]);
    endtask

    task automatic t_reset;
        check("R1 m", m_o, 30);
        check("R1 n", n_o, 1);
        check("R1 ss", ss_o, 0);
        check("R1 tsel", tsel_o, 0);
        check("R1 relock", relock_o, 0);
        check("R1 test", test_o, 0);
    endtask

    task automatic t_parallel;
        int r0;
        mpin = 9'd28; npin = 3'd2; cyc(2);
        r0 = relocks;
        strobe_n = 1'b0; cyc(8);
        check("R2 m follows", m_o, 28);
        check("R2 n follows", n_o, 2);
        check("R2 ss off", ss_o, 0);
        check("R10 one pulse", relocks - r0, 1);
        mpin = 9'd31; npin = 3'd4; cyc(8);
        check("R2 m follows again", m_o, 31);
        check("R2 n follows again", n_o, 4);
        r0 = relocks;
        npin = 3'd6; cyc(8);
        check("R10 n-only no pulse", relocks - r0, 0);
        strobe_n = 1'b1; cyc(8);
        mpin = 9'd20; npin = 3'd0; cyc(8);
        check("R3 m frozen", m_o, 31);
        check("R3 n frozen", n_o, 6);
    endtask

    task automatic t_serial_load;
        int r0;
        send_frame(mk_frame(4'b1010, 2'b01, 3'd5, 9'd27));
        check("R4 m unchanged by shift", m_o, 31);
        check("R4 ss unchanged by shift", ss_o, 0);
        r0 = relocks;
        sld = 1'b1; cyc(8);
        sld = 1'b0; cyc(8);
        check("R5 m", m_o, 27);
        check("R5 n", n_o, 5);
        check("R5 ss", ss_o, 10);
        check("R5 tsel", tsel_o, 1);
        check("R10 serial pulse", relocks - r0, 1);
        check("R7 sel1 shift out", test_o, 1);
    endtask

    task automatic t_test_mux;
        send_frame(mk_frame(4'b0000, 2'b10, 3'd5, 9'd27));
        sld = 1'b1; cyc(8); sld = 1'b0; cyc(8);
        fbclk = 1'b1; cyc(1);
        check("R7 sel2 fb high", test_o, 1);
        fbclk = 1'b0; cyc(1);
        check("R7 sel2 fb low", test_o, 0);
        send_frame(mk_frame(4'b0011, 2'b11, 3'd5, 9'd27));
        sld = 1'b1; cyc(8); sld = 1'b0; cyc(8);
        baclk = 1'b1; fbclk = 1'b1; cyc(1);
        check("R7 sel3 banka", test_o, 1);
        baclk = 1'b0; cyc(1);
        check("R7 sel3 banka low", test_o, 0);
        send_frame(mk_frame(4'b0011, 2'b00, 3'd5, 9'd27));
        sld = 1'b1; cyc(8); sld = 1'b0; cyc(8);
        baclk = 1'b1; cyc(1);
        check("R7 sel0 low", test_o, 0);
        fbclk = 1'b0;
    endtask

    task automatic t_held_load;
        sld = 1'b1; cyc(8);
        send_frame(mk_frame(4'b0101, 2'b11, 3'd3, 9'd33));
        check("R6 m passthrough", m_o, 33);
        check("R6 n passthrough", n_o, 3);
        check("R6 ss passthrough", ss_o, 5);
        sld = 1'b0; cyc(8);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        check("R6 m latched", m_o, 33);
        check("R6 ss latched", ss_o, 5);
    endtask

    task automatic t_master_reset;
        int r0;
        r0 = relocks;
        mr = 1'b1; cyc(10);
        check("R9 m kept", m_o, 33);
        check("R9 ss kept", ss_o, 5);
        check("R9 no pulse while held", relocks - r0, 0);
        mr = 1'b0; cyc(8);
        check("R9 release pulse", relocks - r0, 1);
        check("R9 tsel kept", tsel_o, 3);
    endtask

    task automatic t_parallel_priority;
        mpin = 9'd26; npin = 3'd1; cyc(2);
        strobe_n = 1'b0; cyc(8);
        check("R8 test low parallel", test_o, 0);
        sld = 1'b1; cyc(8);
        send_bit(1'b0);
        check("R11 m from pins", m_o, 26);
        check("R11 ss off", ss_o, 0);
        sld = 1'b0; cyc(8);
        strobe_n = 1'b1; cyc(8);
        check("R11 m latched", m_o, 26);
        check("R11 n latched", n_o, 1);
        baclk = 1'b0;
    endtask

    initial begin
        cyc(5);
        rst_n = 1'b1;
        cyc(5);
        t_reset();
        t_parallel();
        t_serial_load();
        t_test_mux();
        t_held_load();
        t_master_reset();
        t_parallel_priority();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule